// File: doc/BRIEF.md
# Memory-Mapped to Serial-Configuration Register Bridge

This block turns 8-byte memory-mapped register accesses into accesses on an internal serial-configuration register bus. The incoming byte address is first cut down to the window size. It is then folded into a compact register index in one of two ways, chosen by a mode input. One is a packed layout for one chip generation, and the other is a plain divide-by-eight.

A small fixed set of housekeeping indices is answered inside the bridge and never reaches the downstream bus. One of them is the read-only chip identification register. The others read as zero and discard writes. Every other index is sent downstream as a valid/ready transaction at byte offset `index << 3`, and the downstream target may answer with an error.

Each completed access ORs a done flag, and a fail flag when it failed, into a sticky two-bit status register. Only a write-one-to-clear input or reset clears those flags. The requester side uses big-endian byte order, and the bridge swaps bytes in both directions.

Top module: `scom_bridge`

## Requirements
- R1: Only accesses with `req_size` = 3 (8 bytes) are carried out. Any other size completes with `req_err`=1, read data zero, and sets status to fail+done. It is never forwarded.
- R2: Address bits at and above `WIN_LOG2` (default 30) are ignored. An address with bit 31 set reaches the same register as the same address with bit 31 clear.
- R3: With `fold_mode`=0, the index is `{a[29:8], a[6:3]}`, that is `((a>>4) & ~0xF) | ((a>>3) & 0xF)`. Address bit 7 is ignored.
- R4: With `fold_mode`=1, the index is `a >> 3`.
- R5: A read of index 0x0F000F returns the `CHIP_ID` parameter byte-swapped. A write to that index is discarded and not forwarded. A later read still returns `CHIP_ID`.
- R6: These indices read as zero, ignore writes and are never forwarded: 0x0090012, 0x0090013, 0x0090018, 0x00F0033, 0x00F0034, 0x1010C00, 0x1010C03, 0x1020013, 0x1020014, 0x2013028, 0x201302A, 0x2013801, 0x2013802, 0x2020007, 0x2020009, 0x202000F.
- R7: All other indices are forwarded with `ds_addr` = index << 3 and `ds_we` = `req_we`. `ds_wdata` is `req_wdata` byte-reversed, and a successful read returns `ds_rdata` byte-reversed.
- R8: A successful access sets status bit 0 (done) and leaves bit 1 (fail) unchanged.
- R9: A downstream error completes with `req_err`=1 and read data zero, and sets both status bits (bit 1 fail, bit 0 done).
- R10: Status bits only accumulate. A status bit clears only when the matching `stat_clr` bit is pulsed, or on reset. A clear never overrides a set made in the same cycle.
- R11: `req_ready` is a one-cycle pulse that marks completion, and it stays low until downstream completion. `ds_valid` and `ds_addr` hold until `ds_ready`.
- R12: A locally answered access completes one cycle after the accepting edge. A forwarded access completes one cycle after the downstream handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fold_mode | input | 1 | 0 = packed fold, 1 = divide-by-eight fold |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | log2 of access bytes; only 3 is valid |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data, big-endian |
| req_ready | output | 1 | Completion pulse |
| req_rdata | output | 64 | Read data, big-endian, valid with `req_ready` |
| req_err | output | 1 | Access failed, valid with `req_ready` |
| ds_valid | output | 1 | Downstream request valid |
| ds_we | output | 1 | Downstream write |
| ds_addr | output | WIN_LOG2 | Downstream byte offset (index << 3) |
| ds_wdata | output | 64 | Downstream write data |
| ds_ready | input | 1 | Downstream completion, same cycle as response |
| ds_rdata | input | 64 | Downstream read data |
| ds_err | input | 1 | Downstream error response |
| stat_clr | input | 2 | Write-one-to-clear pulse for status bits |
| status | output | 2 | Sticky flags: bit 1 fail, bit 0 done |

## Verification
The bench drives a request on a falling edge and then counts falling edges until `req_ready` is seen. Local and rejected accesses must take exactly one cycle. Forwarded accesses must take two cycles plus the downstream wait that the bench model inserts. Data, error flag and status are all sampled on the falling edge where `req_ready` is first seen, because the bridge updates all three on the edge that enters completion. Forwarded addresses and write data are captured by the downstream model when it raises `ds_ready`, and each is compared with the index the bench placed inside the address.

// File: rtl/scom_bridge_pkg.sv
package scom_bridge_pkg;

  typedef enum logic [1:0] {
    TGT_FWD     = 2'd0,
    TGT_CHIPID  = 2'd1,
    TGT_QUIET   = 2'd2,
    TGT_BADSIZE = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_RESP = 2'd2
  } st_e;

  localparam logic [1:0]  SIZE_8B    = 2'd3;
  localparam logic [31:0] CHIPID_IDX = 32'h000F_000F;

  function automatic logic is_quiet(input logic [31:0] i);
    case (i)
      32'h0202_0009, 32'h0009_0013, 32'h0101_0C03, 32'h0201_3802,
      32'h000F_0034, 32'h0102_0013, 32'h0009_0018, 32'h0201_302A,
      32'h0202_000F, 32'h0101_0C00, 32'h0009_0012, 32'h0201_3801,
      32'h000F_0033, 32'h0102_0014, 32'h0202_0007, 32'h0201_3028:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] swap_bytes(input logic [63:0] d);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/scom_addr_fold.sv
module scom_addr_fold #(
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 30,
  localparam int IW      = WIN_LOG2 - 3
) (
  input  logic              mode_div8,
  input  logic [ADDR_W-1:0] addr,
  output logic [IW-1:0]     idx
);
  logic [WIN_LOG2-1:0] win_addr;
  logic [IW-1:0]       idx_packed;
  logic [IW-1:0]       idx_div8;
  logic                unused_addr_bits;

  assign win_addr = addr[WIN_LOG2-1:0];

  generate
    if (ADDR_W > WIN_LOG2) begin : g_hi
      assign unused_addr_bits = ^{addr[ADDR_W-1:WIN_LOG2], win_addr[7], win_addr[2:0]};
    end else begin : g_nohi
      assign unused_addr_bits = ^{win_addr[7], win_addr[2:0]};
    end
  endgenerate

  assign idx_packed = {1'b0, win_addr[WIN_LOG2-1:8], win_addr[6:3]};
  assign idx_div8   = win_addr[WIN_LOG2-1:3];
  assign idx        = mode_div8 ? idx_div8 : idx_packed;
endmodule

// File: rtl/scom_local_decode.sv
module scom_local_decode
  import scom_bridge_pkg::*;
#(
  parameter int IW = 27
) (
  input  logic [IW-1:0] idx,
  input  logic [1:0]    size,
  output tgt_e          tgt
);
  logic [31:0] idx32;
  assign idx32 = 32'(idx);

  always_comb begin
    if (size != SIZE_8B)            tgt = TGT_BADSIZE;
    else if (idx32 == CHIPID_IDX)   tgt = TGT_CHIPID;
    else if (is_quiet(idx32))       tgt = TGT_QUIET;
    else                            tgt = TGT_FWD;
  end
endmodule

// File: rtl/scom_status.sv
module scom_status (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] set,
  input  logic [1:0] clr,
  output logic [1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 2'b00;
    else     q <= (q & ~clr) | set;
  end

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (clr == 2'b00) |=> ((q & $past(q)) == $past(q)));

  p_done_set_r8: assert property (@(posedge clk) disable iff (rst)
    set[0] |=> q[0]);
endmodule

// File: rtl/scom_bridge.sv
module scom_bridge
  import scom_bridge_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_LOG2 = 30,
  parameter logic [63:0] CHIP_ID  = 64'h0000_00C0_FFEE_0042,
  localparam int         IW       = WIN_LOG2 - 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fold_mode,
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [63:0]         req_wdata,
  output logic                req_ready,
  output logic [63:0]         req_rdata,
  output logic                req_err,
  output logic                ds_valid,
  output logic                ds_we,
  output logic [WIN_LOG2-1:0] ds_addr,
  output logic [63:0]         ds_wdata,
  input  logic                ds_ready,
  input  logic [63:0]         ds_rdata,
  input  logic                ds_err,
  input  logic [1:0]          stat_clr,
  output logic [1:0]          status
);
  st_e           st_q;
  logic [IW-1:0] idx;
  tgt_e          tgt;
  logic [63:0]   rdata_q;
  logic          err_q;
  logic [1:0]    stat_set;

  scom_addr_fold #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_fold (
    .mode_div8 (fold_mode),
    .addr      (req_addr),
    .idx       (idx)
  );

  scom_local_decode #(.IW(IW)) u_dec (
    .idx  (idx),
    .size (req_size),
    .tgt  (tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      rdata_q  <= '0;
      err_q    <= 1'b0;
      ds_we    <= 1'b0;
      ds_addr  <= '0;
      ds_wdata <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          if (tgt == TGT_FWD) begin
            ds_addr  <= {idx, 3'b000};
            ds_we    <= req_we;
            ds_wdata <= swap_bytes(req_wdata);
            st_q     <= ST_FWD;
          end else begin
            rdata_q <= (tgt == TGT_CHIPID && !req_we) ? swap_bytes(CHIP_ID) : 64'd0;
            err_q   <= (tgt == TGT_BADSIZE);
            st_q    <= ST_RESP;
          end
        end
        ST_FWD: if (ds_ready) begin
          rdata_q <= (ds_err || ds_we) ? 64'd0 : swap_bytes(ds_rdata);
          err_q   <= ds_err;
          st_q    <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stat_set = 2'b00;
    if (st_q == ST_IDLE && req_valid && tgt != TGT_FWD)
      stat_set = {tgt == TGT_BADSIZE, 1'b1};
    else if (st_q == ST_FWD && ds_ready)
      stat_set = {ds_err, 1'b1};
  end

  scom_status u_stat (
    .clk (clk),
    .rst (rst),
    .set (stat_set),
    .clr (stat_clr),
    .q   (status)
  );

  assign req_ready = (st_q == ST_RESP);
  assign req_rdata = rdata_q;
  assign req_err   = err_q;
  assign ds_valid  = (st_q == ST_FWD);

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  p_ds_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (ds_valid && !ds_ready) |=> (ds_valid && $stable(ds_addr)));

  p_err_status_r9: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_err) |-> (status == 2'b11));

  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_err) |-> (req_rdata == 64'd0));
endmodule

// File: tb/tb_scom_bridge.sv
module tb_scom_bridge;
  localparam int          AW   = 32;
  localparam int          WL   = 30;
  localparam logic [63:0] CID  = 64'h0000_00C0_FFEE_0042;

  logic clk = 0, rst = 1;
  logic fold_mode = 0, req_valid = 0, req_we = 0;
  logic [1:0] req_size = 3;
  logic [AW-1:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic req_ready, req_err, ds_valid, ds_we;
  logic [63:0] req_rdata, ds_wdata;
  logic [WL-1:0] ds_addr;
  logic ds_ready = 0, ds_err = 0;
  logic [63:0] ds_rdata = 0;
  logic [1:0] stat_clr = 0, status;

  int errors = 0, checks = 0;
  int ds_lat = 0, ds_wait = 0, fwd_cnt = 0;
  logic [WL-1:0] last_addr;
  logic [63:0] last_wdata;
  logic last_we;

  always #2.5 clk = ~clk;

  scom_bridge #(.ADDR_W(AW), .WIN_LOG2(WL), .CHIP_ID(CID)) dut (.*);

  function automatic logic [63:0] bsw(input logic [63:0] d);
    return {<<8{d}};
  endfunction

  function automatic logic [63:0] model(input logic [WL-1:0] a);
    return {32'hC0DE_0000 ^ 32'(a), ~32'(a)};
  endfunction

  always @(negedge clk) begin
    if (ds_ready) begin
      ds_ready = 0; ds_wait = 0;
    end else if (ds_valid) begin
      if (ds_wait >= ds_lat) begin
        ds_ready = 1; ds_rdata = model(ds_addr); ds_err = (ds_addr[10:3] == 8'hEE);
        fwd_cnt++; last_addr = ds_addr; last_we = ds_we; last_wdata = ds_wdata;
      end else ds_wait++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(input logic m, input logic [31:0] idx);
    if (m) return AW'(idx) << 3;
    return (AW'(idx >> 4) << 8) | (AW'(idx & 32'hF) << 3);
  endfunction

  logic [63:0] rd;
  logic er;
  int lat;

  task automatic acc(input logic m, input logic we, input logic [1:0] sz, input logic [AW-1:0] a, input logic [63:0] wd);
    @(negedge clk);
    fold_mode = m; req_we = we; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!req_ready && lat < 200);
    rd = req_rdata; er = req_err; req_valid = 0;
  endtask

  task automatic clear(input logic [1:0] c);
    @(negedge clk); stat_clr = c; @(negedge clk); stat_clr = 0;
  endtask

  logic [31:0] quiet [16] = '{32'h0090012, 32'h0090013, 32'h0090018, 32'h00F0033,
    32'h00F0034, 32'h1010C00, 32'h1010C03, 32'h1020013, 32'h1020014, 32'h2013028,
    32'h201302A, 32'h2013801, 32'h2013802, 32'h2020007, 32'h2020009, 32'h202000F};

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(status == 0 && !req_ready && !ds_valid, "reset", 64'(status), 0);

    // R3 R4 R7 R11 R12: forwarded sweep, both fold modes, reads and writes
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 24; k++) begin
        logic [31:0] idx;
        idx = 32'h0000_0101 * k + 32'h0012_3400 + 32'(k);
        ds_lat = k % 4;
        f0 = fwd_cnt;
        acc(m[0], 0, 3, addr_of(m[0], idx), 0);
        chk(fwd_cnt == f0 + 1 && last_addr == WL'(idx << 3) && !last_we, m ? "R4 addr" : "R3 addr", 64'(last_addr), 64'(idx << 3));
        chk(rd == bsw(model(WL'(idx << 3))) && !er, "R7 rdata", rd, bsw(model(WL'(idx << 3))));
        chk(lat == 2 + ds_lat, "R11 R12 fwd latency", 64'(lat), 64'(2 + ds_lat));
        acc(m[0], 1, 3, addr_of(m[0], idx), 64'h0123_4567_89AB_CDEF ^ 64'(k));
        chk(last_we && last_wdata == bsw(64'h0123_4567_89AB_CDEF ^ 64'(k)), "R7 wdata", last_wdata, bsw(64'h0123_4567_89AB_CDEF ^ 64'(k)));
      end
    end
    ds_lat = 0;

    // R2 window bit, R3 bit 7 ignored in packed mode
    acc(1, 0, 3, addr_of(1, 32'h33_0040) | 32'h8000_0000, 0);
    chk(last_addr == WL'(32'h33_0040 << 3), "R2 window", 64'(last_addr), 64'(32'h33_0040 << 3));
    acc(0, 0, 3, addr_of(0, 32'h33_0041) | 32'h8000_0080, 0);
    chk(last_addr == WL'(32'h33_0041 << 3), "R3 bit7", 64'(last_addr), 64'(32'h33_0041 << 3));

    // R5 chip id
    for (int m = 0; m < 2; m++) begin
      f0 = fwd_cnt;
      acc(m[0], 0, 3, addr_of(m[0], 32'hF000F), 0);
      chk(rd == bsw(CID) && !er && lat == 1, "R5 R12 chipid read", rd, bsw(CID));
      acc(m[0], 1, 3, addr_of(m[0], 32'hF000F), 64'hDEAD);
      acc(m[0], 0, 3, addr_of(m[0], 32'hF000F), 0);
      chk(rd == bsw(CID) && fwd_cnt == f0, "R5 chipid write ignored", rd, bsw(CID));
    end

    // R6 quiet set
    for (int m = 0; m < 2; m++) begin
      for (int q = 0; q < 16; q++) begin
        f0 = fwd_cnt;
        acc(m[0], 1, 3, addr_of(m[0], quiet[q]), 64'hFFFF_FFFF_FFFF_FFFF);
        acc(m[0], 0, 3, addr_of(m[0], quiet[q]), 0);
        chk(rd == 0 && !er && lat == 1 && fwd_cnt == f0, "R6 quiet", rd, 0);
      end
    end

    // R1 bad size
    for (int s = 0; s < 3; s++) begin
      clear(2'b11);
      f0 = fwd_cnt;
      acc(1, 0, s[1:0], addr_of(1, 32'h44_0000), 0);
      chk(er && rd == 0 && fwd_cnt == f0 && status == 2'b11 && lat == 1, "R1 size", {rd[61:0], er, 1'b0}, 64'd2);
    end

    // R8 R9 R10 status behaviour
    clear(2'b11);
    chk(status == 2'b00, "R10 clear", 64'(status), 0);
    acc(1, 0, 3, addr_of(1, 32'h55_0000), 0);
    chk(status == 2'b01 && !er, "R8 done", 64'(status), 1);
    acc(1, 0, 3, addr_of(1, 32'h55_00EE), 0);
    chk(er && rd == 0 && status == 2'b11, "R9 ds error", {rd[62:0], er}, 64'd1);
    repeat (4) @(negedge clk);
    chk(status == 2'b11, "R10 sticky", 64'(status), 3);
    clear(2'b01);
    chk(status == 2'b10, "R10 partial clear", 64'(status), 2);
    acc(0, 1, 3, addr_of(0, 32'h55_0001), 0);
    chk(status == 2'b11 && !er, "R8 R10 accumulate", 64'(status), 3);
    ds_lat = 3;
    acc(1, 1, 3, addr_of(1, 32'h66_01EE), 0);
    chk(er && lat == 5, "R9 R11 write error", 64'(lat), 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule